// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences the low-power states of a small 8-bit microcontroller core. Software asks for a light sleep (idle) or a deep sleep (power-down). In idle the CPU clock is gated while the peripheral clock keeps running. In power-down the oscillator enable is also dropped. For each state the block sets the external bus strobe levels and the port 0 float control. The port 0 float control depends on whether code is being fetched from internal or external program memory.

A hardware reset pin is synchronised through a shift chain. The synchronised reset reinitialises the special function registers through `sfr_init_o`. After the chip wakes from power-down, that reinitialisation is stretched by a fixed number of extra cycles so that the oscillator can settle before the CPU clock comes back. A small register-file model stands in for the on-chip RAM. Its contents are never cleared by reset. Writes to it are blocked while a reset is travelling through the synchroniser. When reset ends an idle period, the core runs for a short window before the internal reset takes over: port writes still pass in that window, but RAM writes do not.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `mode_o` encodes RUN=0, IDLE=1, PDOWN=2 and reads RUN after reset. When the CPU is running and `idle_req_i` is high with `pdown_req_i` low, the next cycle is IDLE: `cpu_clk_en_o`=0, `periph_clk_en_o`=1, `osc_en_o`=1. Requests are ignored outside RUN.
- R2: In IDLE, a wake happens when any bit of `irq_pend_i & irq_en_i` is set, and the next cycle is RUN. A pending bit whose enable is 0 has no effect.
- R3: In PDOWN, `cpu_clk_en_o`, `periph_clk_en_o` and `osc_en_o` are all 0. Interrupts and requests are ignored, and only the hardware reset leaves the state.
- R4: If idle and power-down are requested in the same cycle, power-down wins.
- R5: The strobes depend on the mode. In IDLE, `ale_o`=`psen_o`=1. In PDOWN, both are 0. In RUN, they follow `ale_run_i` and `psen_run_i`.
- R6: `p0_float_o` equals `ext_code_i` (1 = external program memory) in IDLE and PDOWN, and is 0 in RUN.
- R7: `sfr_init_o` rises SYNC_STAGES clock edges after `hw_rst_i` rises. After a reset that did not start in PDOWN, it falls together with the synchronised reset. `cpu_clk_en_o` is 0 whenever `sfr_init_o` is 1.
- R8: A reset seen in PDOWN returns the mode to RUN with `osc_en_o`=1. After the synchronised reset falls, `sfr_init_o` stays high for STAB_CYC further cycles.
- R9: A reset arriving in IDLE returns the mode to RUN two edges after the pin rises. The core then runs for SYNC_STAGES-2 cycles with `cpu_clk_en_o`=1 and `sfr_init_o`=0. In that window RAM writes are dropped, and `port_we_o` follows `port_we_i`.
- R10: RAM contents survive power-down and every reset. A write takes effect only when `cpu_clk_en_o`=1 and no reset is in flight. `ram_rdata_o` shows the word at `ram_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| hw_rst_i | input | 1 | Hardware reset pin, active high, asynchronous |
| idle_req_i | input | 1 | Software idle request |
| pdown_req_i | input | 1 | Software power-down request |
| irq_pend_i | input | IRQ_W | Interrupt pending flags |
| irq_en_i | input | IRQ_W | Interrupt enable flags |
| ext_code_i | input | 1 | 1 = code fetched from external program memory |
| ale_run_i | input | 1 | Address latch strobe from the core in RUN |
| psen_run_i | input | 1 | Program store strobe from the core in RUN |
| ram_we_i | input | 1 | RAM write request |
| ram_addr_i | input | RAM_AW | RAM address |
| ram_wdata_i | input | RAM_DW | RAM write data |
| port_we_i | input | 1 | Port write request from the core |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| ale_o | output | 1 | Address latch strobe pin level |
| psen_o | output | 1 | Program store strobe pin level |
| p0_float_o | output | 1 | Port 0 float control |
| sfr_init_o | output | 1 | Special function register reinitialise |
| mode_o | output | 2 | Mode status: 0 RUN, 1 IDLE, 2 PDOWN |
| ram_rdata_o | output | RAM_DW | RAM read data |
| port_we_o | output | 1 | Port write enable to the port registers |

## Verification
Some behaviours are checked by assertions on every cycle:
- power-down wins over idle;
- power-down holds until the synchronised reset;
- an enabled interrupt or an early reset wakes idle;
- the strobe and float levels match each low-power mode;
- the CPU clock is gated during reinitialisation;
- port writes pass during the reset window;
- RAM stays unchanged when no write is accepted.

Other behaviours only the bench scenarios can show, because they depend on counting cycles across whole sequences:
- the exact synchroniser latency;
- the length of the stretched reinitialisation after power-down compared with an ordinary reset pulse;
- the position and length of the idle-to-reset execution window;
- RAM contents surviving a full power-down and wake.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } mode_e;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int SYNC_STAGES = 4,
  parameter int STAB_CYC    = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_rst_i,
  input  logic in_pdown_i,
  output logic rst_seen_o,
  output logic rst_guard_o,
  output logic rst_sync_o,
  output logic sfr_init_o
);
  localparam int CW = $clog2(STAB_CYC + 1);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [CW-1:0]          cnt_q;
  logic                   pd_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-2:0], hw_rst_i};
  end

  assign rst_seen_o  = chain_q[0];
  assign rst_guard_o = |chain_q;
  assign rst_sync_o  = chain_q[SYNC_STAGES-1];

  // stretch reinit after a wake from power-down so the oscillator settles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pd_seen_q <= 1'b0;
    end else if (rst_sync_o) begin
      pd_seen_q <= pd_seen_q | in_pdown_i;
      if (pd_seen_q || in_pdown_i) cnt_q <= CW'(STAB_CYC);
    end else begin
      pd_seen_q <= 1'b0;
      if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign sfr_init_o = rst_sync_o | (cnt_q != '0);

  assert_stab_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rst_sync_o) && $past(pd_seen_q)) |-> sfr_init_o);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  idle_req_i,
  input  logic  pdown_req_i,
  input  logic  irq_wake_i,
  input  logic  rst_seen_i,
  input  logic  rst_sync_i,
  input  logic  sfr_init_i,
  output mode_e mode_o,
  output logic  cpu_clk_en_o,
  output logic  periph_clk_en_o,
  output logic  osc_en_o
);
  mode_e mode_q, mode_d;
  logic  run_ok;

  assign run_ok = (mode_q == MODE_RUN) && !sfr_init_i;

  always_comb begin
    mode_d = mode_q;
    if (rst_sync_i) mode_d = MODE_RUN;
    else begin
      unique case (mode_q)
        MODE_RUN: begin
          if (run_ok && pdown_req_i)     mode_d = MODE_PDOWN;
          else if (run_ok && idle_req_i) mode_d = MODE_IDLE;
        end
        // reset pin seen in idle: core resumes before internal reset lands
        MODE_IDLE:  if (irq_wake_i || rst_seen_i) mode_d = MODE_RUN;
        MODE_PDOWN: mode_d = MODE_PDOWN;
        default:    mode_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RUN;
    else         mode_q <= mode_d;
  end

  assign mode_o          = mode_q;
  assign cpu_clk_en_o    = run_ok;
  assign periph_clk_en_o = (mode_q != MODE_PDOWN);
  assign osc_en_o        = (mode_q != MODE_PDOWN);

  assert_idle_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_ok && idle_req_i && !pdown_req_i && !rst_sync_i) |=> (mode_q == MODE_IDLE));
  assert_irq_wake_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_IDLE && irq_wake_i) |=> (mode_q == MODE_RUN));
  assert_pd_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PDOWN && !rst_sync_i) |=> (mode_q == MODE_PDOWN));
  assert_pd_prio_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_ok && pdown_req_i && idle_req_i && !rst_sync_i) |=> (mode_q == MODE_PDOWN));
  assert_rst_wake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_IDLE && rst_seen_i) |=> (mode_q == MODE_RUN));
endmodule

// File: rtl/pwr_pin_mux.sv
module pwr_pin_mux
  import pwr_mode_pkg::*;
(
  input  mode_e mode_i,
  input  logic  ext_code_i,
  input  logic  ale_run_i,
  input  logic  psen_run_i,
  output logic  ale_o,
  output logic  psen_o,
  output logic  p0_float_o
);
  always_comb begin
    unique case (mode_i)
      MODE_IDLE:  begin ale_o = 1'b1;      psen_o = 1'b1;       p0_float_o = ext_code_i; end
      MODE_PDOWN: begin ale_o = 1'b0;      psen_o = 1'b0;       p0_float_o = ext_code_i; end
      default:    begin ale_o = ale_run_i; psen_o = psen_run_i; p0_float_o = 1'b0;       end
    endcase
  end
endmodule

// File: rtl/pwr_ram_model.sv
module pwr_ram_model #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          wr_ok_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  // no reset on the array: contents survive every reset
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && wr_ok_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

  assert_ram_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && wr_ok_i) |=> (!$stable(addr_i) || $stable(rdata_o)));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 4,
  parameter int STAB_CYC    = 5,
  parameter int IRQ_W       = 2,
  parameter int RAM_AW      = 4,
  parameter int RAM_DW      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_rst_i,
  input  logic              idle_req_i,
  input  logic              pdown_req_i,
  input  logic [IRQ_W-1:0]  irq_pend_i,
  input  logic [IRQ_W-1:0]  irq_en_i,
  input  logic              ext_code_i,
  input  logic              ale_run_i,
  input  logic              psen_run_i,
  input  logic              ram_we_i,
  input  logic [RAM_AW-1:0] ram_addr_i,
  input  logic [RAM_DW-1:0] ram_wdata_i,
  input  logic              port_we_i,
  output logic              cpu_clk_en_o,
  output logic              periph_clk_en_o,
  output logic              osc_en_o,
  output logic              ale_o,
  output logic              psen_o,
  output logic              p0_float_o,
  output logic              sfr_init_o,
  output logic [1:0]        mode_o,
  output logic [RAM_DW-1:0] ram_rdata_o,
  output logic              port_we_o
);
  mode_e mode;
  logic  rst_seen, rst_guard, rst_sync, irq_wake;

  assign irq_wake = |(irq_pend_i & irq_en_i);

  pwr_rst_sync #(.SYNC_STAGES(SYNC_STAGES), .STAB_CYC(STAB_CYC)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hw_rst_i    (hw_rst_i),
    .in_pdown_i  (mode == MODE_PDOWN),
    .rst_seen_o  (rst_seen),
    .rst_guard_o (rst_guard),
    .rst_sync_o  (rst_sync),
    .sfr_init_o  (sfr_init_o)
  );

  pwr_mode_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .idle_req_i      (idle_req_i),
    .pdown_req_i     (pdown_req_i),
    .irq_wake_i      (irq_wake),
    .rst_seen_i      (rst_seen),
    .rst_sync_i      (rst_sync),
    .sfr_init_i      (sfr_init_o),
    .mode_o          (mode),
    .cpu_clk_en_o    (cpu_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .osc_en_o        (osc_en_o)
  );

  pwr_pin_mux u_pins (
    .mode_i     (mode),
    .ext_code_i (ext_code_i),
    .ale_run_i  (ale_run_i),
    .psen_run_i (psen_run_i),
    .ale_o      (ale_o),
    .psen_o     (psen_o),
    .p0_float_o (p0_float_o)
  );

  pwr_ram_model #(.AW(RAM_AW), .DW(RAM_DW)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we_i),
    .wr_ok_i (cpu_clk_en_o && !rst_guard),
    .addr_i  (ram_addr_i),
    .wdata_i (ram_wdata_i),
    .rdata_o (ram_rdata_o)
  );

  // port writes are not held off by a reset in flight
  assign port_we_o = port_we_i && cpu_clk_en_o;
  assign mode_o    = mode;

  assert_idle_pins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_IDLE) |-> (ale_o && psen_o));
  assert_pd_pins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_PDOWN) |-> (!ale_o && !psen_o && !osc_en_o));
  assert_float_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_RUN) |-> (p0_float_o == ext_code_i));
  assert_cpu_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_init_o |-> !cpu_clk_en_o);
  assert_port_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_guard && cpu_clk_en_o && port_we_i) |-> port_we_o);
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 4;
  localparam int STAB = 5;
  localparam int NV   = 8;

  // {idle,pdown,pend[1:0],en[1:0],ext,ale_run,psen_run | mode[1:0],ale,psen,float,cpu_en,osc_en}
  localparam logic [15:0] VEC [NV] = '{
    16'b0_0_00_00_0_1_0_00_1_0_0_1_1, // run pass-through
    16'b1_0_00_00_0_0_0_01_1_1_0_0_1, // idle, internal code
    16'b0_0_01_10_1_0_0_01_1_1_1_0_1, // masked irq, external code floats
    16'b0_1_00_00_1_0_0_01_1_1_1_0_1, // request ignored in idle
    16'b0_0_10_10_1_0_0_00_0_0_0_1_1, // enabled irq wakes
    16'b1_1_00_00_0_0_0_10_0_0_0_0_0, // both requests: power-down wins
    16'b1_0_11_11_0_1_1_10_0_0_0_0_0, // irq and requests ignored
    16'b0_0_00_00_1_1_1_10_0_0_1_0_0  // external code floats port 0
  };

  logic clk = 1'b0, rst_ni = 1'b0, hw_rst = 1'b0;
  logic idle_req = 1'b0, pdown_req = 1'b0, ext_code = 1'b0, ale_run = 1'b0, psen_run = 1'b0;
  logic [1:0] irq_pend = '0, irq_en = '0;
  logic ram_we = 1'b0, port_we = 1'b0;
  logic [3:0] ram_addr = '0;
  logic [7:0] ram_wdata = '0;
  logic cpu_en, per_en, osc_en, ale, psen, p0_float, sfr_init, port_we_o;
  logic [1:0] mode;
  logic [7:0] ram_rdata;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.SYNC_STAGES(SYNC), .STAB_CYC(STAB)) u_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .hw_rst_i(hw_rst), .idle_req_i(idle_req),
    .pdown_req_i(pdown_req), .irq_pend_i(irq_pend), .irq_en_i(irq_en),
    .ext_code_i(ext_code), .ale_run_i(ale_run), .psen_run_i(psen_run),
    .ram_we_i(ram_we), .ram_addr_i(ram_addr), .ram_wdata_i(ram_wdata),
    .port_we_i(port_we), .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en),
    .osc_en_o(osc_en), .ale_o(ale), .psen_o(psen), .p0_float_o(p0_float),
    .sfr_init_o(sfr_init), .mode_o(mode), .ram_rdata_o(ram_rdata),
    .port_we_o(port_we_o)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int count_init(input int cycles);
    return cycles;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hi;
    step(2);
    // reset state R1 R7
    check("R1 reset mode", mode, 0);
    check("R7 reset sfr_init", sfr_init, 0);
    rst_ni = 1'b1;
    step(1);
    check("R1 reset cpu_en", cpu_en, 1);
    check("R1 reset osc_en", osc_en, 1);

    // R10 write in run
    ram_we = 1'b1; ram_addr = 4'd3; ram_wdata = 8'hA5;
    step(1);
    ram_we = 1'b0;
    check("R10 write in run", ram_rdata, 8'hA5);

    for (int i = 0; i < NV; i++) begin
      {idle_req, pdown_req, irq_pend, irq_en, ext_code, ale_run, psen_run} = VEC[i][15:7];
      step(1);
      check($sformatf("vec%0d mode R1 R2 R3 R4", i), mode, VEC[i][6:5]);
      check($sformatf("vec%0d ale R5", i), ale, VEC[i][4]);
      check($sformatf("vec%0d psen R5", i), psen, VEC[i][3]);
      check($sformatf("vec%0d float R6", i), p0_float, VEC[i][2]);
      check($sformatf("vec%0d cpu_en R1 R3", i), cpu_en, VEC[i][1]);
      check($sformatf("vec%0d osc_en R3", i), osc_en, VEC[i][0]);
      check($sformatf("vec%0d periph R1 R3", i), per_en, VEC[i][0]);
    end
    {idle_req, pdown_req, irq_pend, irq_en} = '0;

    // power-down exit by reset R7 R8
    hw_rst = 1'b1;
    step(SYNC - 1);
    check("R7 sfr_init before latency", sfr_init, 0);
    step(1);
    check("R7 sfr_init at latency", sfr_init, 1);
    check("R3 still pdown at sync", mode, 2);
    step(1);
    check("R8 mode run after pd reset", mode, 0);
    check("R8 osc back", osc_en, 1);
    step(4);
    hw_rst = 1'b0;
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (sfr_init) hi++;
    end
    check("R8 stretched init cycles", hi, count_init(SYNC + STAB - 1));
    check("R8 cpu_en after stretch", cpu_en, 1);
    check("R10 ram kept over pdown", ram_rdata, 8'hA5);

    // ordinary reset pulse from run R7
    hw_rst = 1'b1;
    step(1);
    hw_rst = 1'b0;
    hi = 0;
    for (int k = 0; k < 12; k++) begin
      step(1);
      if (sfr_init) hi++;
    end
    check("R7 plain reset init cycles", hi, 1);

    // reset ends idle R9
    idle_req = 1'b1;
    step(1);
    idle_req = 1'b0;
    check("R1 idle again", mode, 1);
    ram_we = 1'b1; ram_wdata = 8'h5A;
    step(1);
    check("R10 write ignored in idle", ram_rdata, 8'hA5);
    ram_we = 1'b0;
    hw_rst = 1'b1;
    step(1);
    check("R9 idle after one edge", mode, 1);
    step(1);
    check("R9 run in window", mode, 0);
    check("R9 cpu_en in window", cpu_en, 1);
    check("R9 sfr_init low in window", sfr_init, 0);
    ram_we = 1'b1; ram_wdata = 8'h11; port_we = 1'b1;
    #1;
    check("R9 port write passes", port_we_o, 1);
    step(1);
    check("R9 ram write blocked", ram_rdata, 8'hA5);
    check("R9 window second cycle", cpu_en, 1);
    step(1);
    check("R9 internal reset took over", sfr_init, 1);
    check("R7 cpu gated", cpu_en, 0);
    check("R9 port write gated", port_we_o, 0);
    ram_we = 1'b0; port_we = 1'b0; hw_rst = 1'b0;
    step(12);
    check("R10 ram kept over reset", ram_rdata, 8'hA5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule